// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches one external input that changes with no relation to the local clock. It turns activity on that input into an interrupt request. A two-bit sense field picks the kind of activity that counts: a low level, any change, a falling edge or a rising edge. The input first passes through a chain of synchronizing flops. Edges are then found by comparing the synchronized sample with the sample held from the previous clock.

In the three edge modes a detected edge sets a sticky pending flag, which holds until software clears it. In low-level mode no flag is used, and the request follows the synchronized level directly. The request output is asserted only while a local enable bit and a global interrupt-enable input are both set. The flag can still be set while the request is disabled, so an edge that arrives while disabled raises the request as soon as both enables are set. A single-cycle write strobe loads the enable bit and the sense field together. A separate strobe clears the flag.

The block acts on any activity at the pin, whichever device drives it, including the device that contains this block.

Top module: `pin_event_irq`

## Requirements
- R1: Out of reset, `flag_o` and `irq_o` are 0, the local enable is 0 and the sense field is 00 (low level). With the pin held low and `glob_en_i` at 1, `irq_o` stays 0 until the enable is written to 1.
- R2: With sense 00, `irq_o` equals local enable AND `glob_en_i` AND NOT (synchronized pin), and `flag_o` never rises.
- R3: With sense 01, both a rising and a falling transition of the synchronized pin set `flag_o`.
- R4: With sense 10, a falling transition sets `flag_o` and a rising transition leaves it unchanged.
- R5: With sense 11, a rising transition sets `flag_o` and a falling transition leaves it unchanged.
- R6: The pin passes through SYNC_STAGES flops (default 2) before edge comparison. A pin change driven between clock edges appears on `flag_o` after the third following rising edge and not after the second.
- R7: In any edge mode, a pin pulse lasting two clock periods always sets `flag_o`.
- R8: In edge modes, `irq_o` equals local enable AND `glob_en_i` AND `flag_o`. The flag is set while either enable is 0 and raises `irq_o` once both are 1.
- R9: `clr_flag_i` = 1 clears `flag_o` at the next edge, unless an edge is detected in the same cycle, in which case the flag stays 1.
- R10: In the cycle in which a write changes the sense field, any detected edge is discarded and does not set `flag_o`.
- R11: `wr_en_i` = 1 loads `wr_mask_i` into the local enable and `wr_sense_i` into the sense field at the next rising edge (sense codes 00 low, 01 any, 10 fall, 11 rise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External pin, asynchronous |
| glob_en_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_mask_i | input | 1 | Local enable value to write |
| wr_sense_i | input | 2 | Sense code to write |
| clr_flag_i | input | 1 | Clear pending flag |
| flag_o | output | 1 | Pending edge flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A stale previous-sample register would show up on `flag_o` within one clock of the next pin transition, as a missed edge or a false one. A wrong sense field or enable bit would show on `irq_o` in the cycle after the write. A flag that fails to clear or holds a stuck value shows up one clock after a clear strobe. The bench runs a cycle-by-cycle reference model and compares both outputs on every clock, so each of these faults is reported within a cycle or two of its cause.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic   en;
        sense_e sense;
    } irq_cfg_t;

    typedef struct packed {
        logic prev;
    } edge_st_t;

    typedef struct packed {
        logic flag;
    } pend_st_t;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            assign chain_d = d_i;
        end else begin : g_many
            assign chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_cfg.sv
module eirq_cfg
    import ext_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic       wr_mask_i,
    input  logic [1:0] wr_sense_i,
    output logic       en_o,
    output sense_e     sense_o,
    output logic       chg_o
);
    irq_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            cfg_d.en    = wr_mask_i;
            cfg_d.sense = sense_e'(wr_sense_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '{en: 1'b0, sense: SENSE_LOW};
        else         cfg_q <= cfg_d;
    end

    assign en_o    = cfg_q.en;
    assign sense_o = cfg_q.sense;
    // a write that alters the mode: the edge seen in this cycle is discarded
    assign chg_o   = wr_en_i && (sense_e'(wr_sense_i) != cfg_q.sense);
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge
    import ext_irq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   sample_i,
    input  sense_e sense_i,
    input  logic   suppress_i,
    output logic   hit_o
);
    edge_st_t st_d, st_q;
    logic     rise, fall, hit;

    always_comb begin
        st_d.prev = sample_i;
        rise      = sample_i & ~st_q.prev;
        fall      = ~sample_i & st_q.prev;
        unique case (sense_i)
            SENSE_LOW:  hit = 1'b0;
            SENSE_ANY:  hit = rise | fall;
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
            default:    hit = 1'b0;
        endcase
        if (suppress_i) hit = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prev: 1'b1};
        else         st_q <= st_d;
    end

    assign hit_o = hit;
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import ext_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pin_i,
    input  logic       glob_en_i,
    input  logic       wr_en_i,
    input  logic       wr_mask_i,
    input  logic [1:0] wr_sense_i,
    input  logic       clr_flag_i,
    output logic       flag_o,
    output logic       irq_o
);
    localparam int unsigned STAGES_USED = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic     pin_s;
    logic     cfg_en;
    sense_e   cfg_sense;
    logic     cfg_chg;
    logic     edge_hit;
    pend_st_t pend_d, pend_q;
    logic     cond;

    eirq_sync #(.STAGES(STAGES_USED), .RST_VAL(1'b1)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    eirq_cfg u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_mask_i (wr_mask_i),
        .wr_sense_i(wr_sense_i),
        .en_o      (cfg_en),
        .sense_o   (cfg_sense),
        .chg_o     (cfg_chg)
    );

    eirq_edge u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sample_i  (pin_s),
        .sense_i   (cfg_sense),
        .suppress_i(cfg_chg),
        .hit_o     (edge_hit)
    );

    always_comb begin
        pend_d = pend_q;
        if (edge_hit)        pend_d.flag = 1'b1;
        else if (clr_flag_i) pend_d.flag = 1'b0;
        cond = (cfg_sense == SENSE_LOW) ? ~pin_s : pend_q.flag;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '{flag: 1'b0};
        else         pend_q <= pend_d;
    end

    assign flag_o = pend_q.flag;
    assign irq_o  = cfg_en & glob_en_i & cond;
endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       irq_o,
    input logic       flag_o,
    input logic       glob_en_i,
    input logic       wr_en_i,
    input logic       wr_mask_i,
    input logic [1:0] wr_sense_i,
    input logic       clr_flag_i,
    input logic       hit_i,
    input logic       en_q,
    input logic [1:0] sense_q
);
    // R8
    irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (glob_en_i && en_q));

    // R9
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i |=> flag_o);

    // R9
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_flag_i && !hit_i) |=> !flag_o);

    // R2
    level_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sense_q == 2'b00) |=> !$rose(flag_o));

    // R10
    chg_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_sense_i != sense_q) && !flag_o) |=> !flag_o);

    // R11
    cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (en_q == $past(wr_mask_i) && sense_q == $past(wr_sense_i)));
endmodule

bind pin_event_irq pin_event_irq_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_o     (irq_o),
    .flag_o    (flag_o),
    .glob_en_i (glob_en_i),
    .wr_en_i   (wr_en_i),
    .wr_mask_i (wr_mask_i),
    .wr_sense_i(wr_sense_i),
    .clr_flag_i(clr_flag_i),
    .hit_i     (edge_hit),
    .en_q      (cfg_en),
    .sense_q   (cfg_sense)
);

// File: tb/pin_event_irq_bench.sv
module pin_event_irq_bench;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b1;
    logic       glob = 1'b0;
    logic       wr = 1'b0;
    logic       wmask = 1'b0;
    logic [1:0] wsense = 2'b00;
    logic       clr = 1'b0;
    logic       flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pin_event_irq #(.SYNC_STAGES(SYNC)) u_pin_event_irq (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .glob_en_i(glob),
        .wr_en_i(wr), .wr_mask_i(wmask), .wr_sense_i(wsense),
        .clr_flag_i(clr), .flag_o(flag), .irq_o(irq)
    );

    // behavioural reference
    bit m_q[$];
    bit m_prev, m_flag, m_en;
    int m_sense;

    function automatic bit m_cur();
        return m_q[SYNC-1];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q = {};
            for (int i = 0; i < SYNC; i++) m_q.push_back(1'b1);
            m_prev = 1; m_flag = 0; m_en = 0; m_sense = 0;
        end else begin
            bit c, hit;
            bit changed;
            c = m_cur();
            changed = wr && (int'(wsense) != m_sense);
            case (m_sense)
                1: hit = (c != m_prev);
                2: hit = m_prev && !c;
                3: hit = !m_prev && c;
                default: hit = 0;
            endcase
            if (changed) hit = 0;
            if (hit) m_flag = 1;
            else if (clr) m_flag = 0;
            m_prev = c;
            if (wr) begin m_en = wmask; m_sense = int'(wsense); end
            m_q.push_front(pin);
            void'(m_q.pop_back());
        end
    end

    function automatic bit m_irq();
        bit cond;
        cond = (m_sense == 0) ? !m_cur() : m_flag;
        return m_en && glob && cond;
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // advance one clock and compare against the model at the falling edge
    task automatic tick();
        string tag;
        @(negedge clk);
        case (m_sense)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R4";
            default: tag = "R5";
        endcase
        check(tag, flag, m_flag, "model flag");
        check(tag, irq, m_irq(), "model irq");
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_cfg(bit en, logic [1:0] s);
        wr = 1; wmask = en; wsense = s;
        tick();
        wr = 0;
    endtask

    task automatic clear_flag();
        clr = 1; tick(); clr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1", flag, 1'b0, "flag after reset");
        check("R1", irq, 1'b0, "irq after reset");
        glob = 1; pin = 0;
        ticks(4);
        check("R1", irq, 1'b0, "irq with enable cleared");
        // R11 write enable, sense kept at low level; R2 level request
        write_cfg(1, 2'b00);
        check("R11", irq, 1'b1, "irq after enable write");
        pin = 1; ticks(2);
        check("R2", irq, 1'b0, "irq after pin high");
        check("R2", flag, 1'b0, "no flag in level mode");
        pin = 0; ticks(2);
        check("R2", irq, 1'b1, "irq for low pin");
        pin = 1; ticks(3);

        // R6 latency in falling mode
        write_cfg(1, 2'b10);
        ticks(3);
        pin = 0;
        ticks(2);
        check("R6", flag, 1'b0, "flag after two edges");
        tick();
        check("R6", flag, 1'b1, "flag after three edges");
        check("R8", irq, 1'b1, "irq for pending flag");
        // R9 clear
        clear_flag();
        check("R9", flag, 1'b0, "flag after clear");
        // R4 rising ignored in falling mode
        pin = 1; ticks(4);
        check("R4", flag, 1'b0, "rise in falling mode");

        // R5 rising mode
        write_cfg(1, 2'b11);
        ticks(2);
        pin = 0; ticks(4);
        check("R5", flag, 1'b0, "fall in rising mode");
        pin = 1; ticks(3);
        check("R5", flag, 1'b1, "rise in rising mode");
        clear_flag();

        // R3 any-change mode, R7 two-cycle pulse
        write_cfg(1, 2'b01);
        ticks(3);
        pin = 0; ticks(3);
        check("R3", flag, 1'b1, "fall in any mode");
        clear_flag();
        ticks(2);
        pin = 1; ticks(3);
        check("R3", flag, 1'b1, "rise in any mode");
        clear_flag();
        ticks(2);
        write_cfg(1, 2'b11);
        ticks(2);
        pin = 0; ticks(2); pin = 1; ticks(4);
        check("R7", flag, 1'b1, "two-cycle low pulse caught");
        clear_flag();

        // R8 flag set while disabled, request once enabled
        glob = 0;
        pin = 0; ticks(3); pin = 1; ticks(3);
        check("R8", flag, 1'b1, "flag sets with global enable off");
        check("R8", irq, 1'b0, "irq gated by global enable");
        glob = 1; tick();
        check("R8", irq, 1'b1, "irq after global enable");

        // R9 edge wins over clear (flag already 1)
        pin = 0; ticks(3); pin = 1; ticks(2);
        clr = 1; tick(); clr = 0;
        check("R9", flag, 1'b1, "edge beats clear");
        clear_flag();

        // R10 sense change in the hit cycle discards the edge
        write_cfg(1, 2'b01);
        ticks(2);
        pin = 0; ticks(2);
        wr = 1; wmask = 1; wsense = 2'b10; tick(); wr = 0;
        check("R10", flag, 1'b0, "edge dropped on sense change");
        ticks(3);
        check("R10", flag, 1'b0, "flag still clear");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            pin  = ($urandom % 3) == 0 ? ~pin : pin;
            glob = ($urandom % 10) != 0;
            clr  = ($urandom % 12) == 0;
            wr   = ($urandom % 40) == 0;
            wmask = ($urandom % 5) != 0;
            wsense = 2'($urandom);
            tick();
        end
        wr = 0; clr = 0;
        ticks(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule